// File: doc/BRIEF.md
# Receive DMA Error Offset Recorder

This block sits beside a serial receiver whose characters are moved out of a receive FIFO into memory by a DMA engine that alternates between two buffers, called A and B. It counts the characters that land in the buffer currently in use. It remembers where in that buffer the first damaged character landed, meaning a character with a parity or framing error. Software can then tell how much of a received buffer is trustworthy without scanning it.

A receive overrun is also recorded against the buffer in use. When the FIFO input loses a character, the DMA side has not yet drained the characters already queued ahead of it. The offset recorded for an overrun is therefore the current transfer count plus a fixed lead of four characters. Each buffer keeps its own flag and offset. Both are cleared by that buffer's DMA reset control, or by arming the buffer again after it has finished.

Top module: `rxerr_offset_rec`

## Requirements
- R1: After reset, buffer A is the active buffer (`act_b_o` = 0). Both buffers are idle (`busy_*_o` = 0), both error flags are 0 and both error offsets are 0.
- R2: A load strobe on an idle buffer makes that buffer busy at the next clock edge, with its transfer count at 0 and its error flag and offset cleared. A load strobe on a busy buffer has no effect, and an error it holds stays set.
- R3: Each transfer strobe into the active busy buffer advances that buffer's count by one. A transfer while the active buffer is idle is ignored, even if it carries an error flag.
- R4: The first transferred character of a busy buffer with a parity error or a frame error (either flag) sets that buffer's error flag. Its offset is recorded, which is the number of characters transferred into the buffer before it. Both are visible one clock after the strobe.
- R5: Once a buffer's error flag is set, later flagged characters and overruns do not change its flag or offset.
- R6: An overrun strobe while the active buffer is busy and error-free records an offset equal to that buffer's transfer count plus OVF_LEAD (4). If a flagged transfer occurs in the same cycle, the transfer's own offset is recorded instead.
- R7: The BUF_CHARS-th transfer (8 by default) makes the active buffer idle. If the other buffer is busy, the active buffer switches to it at that same edge. Otherwise the switch happens on the edge after the other buffer becomes busy.
- R8: A DMA reset control makes its buffer idle and clears its error flag and offset at the next edge. It takes precedence over a load strobe in the same cycle.
- R9: An error flag and offset stay readable after the buffer completes, until that buffer is reloaded or reset.
- R10: An overrun strobe while the active buffer is idle changes no error flag or offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_i | input | 1 | One character moved from FIFO to the active buffer |
| par_err_i | input | 1 | Parity error flag stored with the transferred character |
| frm_err_i | input | 1 | Frame error flag stored with the transferred character |
| ovf_i | input | 1 | Receive overrun event at the FIFO input |
| load_a_i | input | 1 | Arm buffer A |
| load_b_i | input | 1 | Arm buffer B |
| dmarst_a_i | input | 1 | Reset buffer A's DMA state and error indication |
| dmarst_b_i | input | 1 | Reset buffer B's DMA state and error indication |
| act_b_o | output | 1 | Active buffer: 0 = A, 1 = B |
| busy_a_o | output | 1 | Buffer A armed and not yet complete |
| busy_b_o | output | 1 | Buffer B armed and not yet complete |
| err_vld_a_o | output | 1 | Buffer A holds an error offset |
| err_off_a_o | output | EOFF_W (4) | Buffer A error offset |
| err_vld_b_o | output | 1 | Buffer B holds an error offset |
| err_off_b_o | output | EOFF_W (4) | Buffer B error offset |

## Verification
Every output is registered. A strobe driven in one cycle shows its effect on the ports after exactly one clock edge. The one exception is the deferred buffer switch of R7, which takes a second edge after the load that arms the other buffer. The bench drives each stimulus on a falling edge and queues the expected port state for that cycle. A monitor compares the queued entry one nanosecond after the following rising edge, so each result is checked in the exact cycle it is due, never earlier or later.

// File: rtl/rxerr_pkg.sv
// Package: shared identifiers for the receive error offset recorder.
// Assumes two buffers only; index 0 is buffer A, index 1 is buffer B.
package rxerr_pkg;
    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_id_e;

    localparam int unsigned NUM_BUFS = 2;
endpackage

// File: rtl/rxerr_buf.sv
// rxerr_buf: state of one DMA receive buffer. It holds the armed flag and the
// transfer counter, and captures the first error offset.
// Assumes BUF_CHARS >= 2; act_i is high while this buffer is the active one.
module rxerr_buf #(
    parameter int unsigned BUF_CHARS = 8,
    parameter int unsigned OVF_LEAD  = 4,
    localparam int unsigned CNT_W    = $clog2(BUF_CHARS),
    localparam int unsigned EOFF_W   = $clog2(BUF_CHARS + OVF_LEAD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_i,
    input  logic              load_i,
    input  logic              clr_i,
    input  logic              xfer_i,
    input  logic              bad_i,
    input  logic              ovf_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_vld_o,
    output logic [EOFF_W-1:0] err_off_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BUF_CHARS - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;
    logic              vld_q;
    logic [EOFF_W-1:0] off_q;
    logic              hit;
    logic              ovf_hit;

    // Qualify strobes: only the active, armed buffer reacts.
    always_comb begin
        hit     = act_i && busy_q && xfer_i;
        ovf_hit = act_i && busy_q && ovf_i;
        done_o  = hit && (cnt_q == LAST);
    end

    // Buffer state: reset and clear first, then load, then transfer and capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            vld_q  <= 1'b0;
            off_q  <= '0;
        end else if (load_i && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            vld_q  <= 1'b0;
            off_q  <= '0;
        end else begin
            if (hit) begin
                cnt_q <= done_o ? '0 : cnt_q + 1'b1;
            end
            if (done_o) begin
                busy_q <= 1'b0;
            end
            if (!vld_q) begin
                if (hit && bad_i) begin
                    vld_q <= 1'b1;
                    off_q <= EOFF_W'(cnt_q);
                end else if (ovf_hit) begin
                    vld_q <= 1'b1;
                    off_q <= EOFF_W'(cnt_q) + EOFF_W'(OVF_LEAD);
                end
            end
        end
    end

    assign busy_o    = busy_q;
    assign err_vld_o = vld_q;
    assign err_off_o = off_q;
endmodule

// File: rtl/rxerr_sel.sv
// rxerr_sel: active-buffer pointer. The pointer moves to the other buffer when
// that buffer is armed and the current one either completes now or is idle.
// Assumes busy_i/done_i are indexed by rxerr_pkg::buf_id_e.
module rxerr_sel
    import rxerr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_BUFS-1:0] busy_i,
    input  logic [NUM_BUFS-1:0] done_i,
    output buf_id_e             act_o
);
    buf_id_e act_q;
    logic    flip;

    // Decide whether to hand over to the other buffer this cycle.
    always_comb begin
        flip = busy_i[~act_q] && (done_i[act_q] || !busy_i[act_q]);
    end

    // Pointer register, starting at buffer A.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= BUF_A;
        end else if (flip) begin
            act_q <= (act_q == BUF_A) ? BUF_B : BUF_A;
        end
    end

    assign act_o = act_q;
endmodule

// File: rtl/rxerr_offset_rec.sv
// rxerr_offset_rec: records, per A/B receive DMA buffer, the offset of the
// first character with a parity/frame error, or an overrun offset that runs
// OVF_LEAD characters ahead. Assumes one transfer strobe per character moved.
module rxerr_offset_rec
    import rxerr_pkg::*;
#(
    parameter int unsigned BUF_CHARS = 8,
    parameter int unsigned OVF_LEAD  = 4,
    localparam int unsigned EOFF_W   = $clog2(BUF_CHARS + OVF_LEAD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_i,
    input  logic              par_err_i,
    input  logic              frm_err_i,
    input  logic              ovf_i,
    input  logic              load_a_i,
    input  logic              load_b_i,
    input  logic              dmarst_a_i,
    input  logic              dmarst_b_i,
    output logic              act_b_o,
    output logic              busy_a_o,
    output logic              busy_b_o,
    output logic              err_vld_a_o,
    output logic [EOFF_W-1:0] err_off_a_o,
    output logic              err_vld_b_o,
    output logic [EOFF_W-1:0] err_off_b_o
);
    logic [NUM_BUFS-1:0] load_v;
    logic [NUM_BUFS-1:0] clr_v;
    logic [NUM_BUFS-1:0] busy_v;
    logic [NUM_BUFS-1:0] done_v;
    logic [NUM_BUFS-1:0] vld_v;
    logic [EOFF_W-1:0]   off_v [NUM_BUFS];
    buf_id_e             act;
    logic                bad;

    // Gather per-buffer controls and merge the two error flags.
    always_comb begin
        load_v = {load_b_i, load_a_i};
        clr_v  = {dmarst_b_i, dmarst_a_i};
        bad    = par_err_i || frm_err_i;
    end

    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
        rxerr_buf #(
            .BUF_CHARS (BUF_CHARS),
            .OVF_LEAD  (OVF_LEAD)
        ) u_buf (
            .clk       (clk),
            .rst_n     (rst_n),
            .act_i     (act == buf_id_e'(g)),
            .load_i    (load_v[g]),
            .clr_i     (clr_v[g]),
            .xfer_i    (xfer_i),
            .bad_i     (bad),
            .ovf_i     (ovf_i),
            .busy_o    (busy_v[g]),
            .done_o    (done_v[g]),
            .err_vld_o (vld_v[g]),
            .err_off_o (off_v[g])
        );
    end

    rxerr_sel u_sel (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy_i (busy_v),
        .done_i (done_v),
        .act_o  (act)
    );

    assign act_b_o     = (act == BUF_B);
    assign busy_a_o    = busy_v[BUF_A];
    assign busy_b_o    = busy_v[BUF_B];
    assign err_vld_a_o = vld_v[BUF_A];
    assign err_off_a_o = off_v[BUF_A];
    assign err_vld_b_o = vld_v[BUF_B];
    assign err_off_b_o = off_v[BUF_B];
endmodule

// File: rtl/rxerr_offset_rec_chk.sv
// rxerr_offset_rec_chk: port-level properties of the error offset recorder,
// bound into every instance of rxerr_offset_rec.
module rxerr_offset_rec_chk #(
    parameter int unsigned EOFF_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xfer_i,
    input logic              par_err_i,
    input logic              frm_err_i,
    input logic              load_a_i,
    input logic              load_b_i,
    input logic              dmarst_a_i,
    input logic              dmarst_b_i,
    input logic              act_b_o,
    input logic              busy_a_o,
    input logic              busy_b_o,
    input logic              err_vld_a_o,
    input logic [EOFF_W-1:0] err_off_a_o,
    input logic              err_vld_b_o,
    input logic [EOFF_W-1:0] err_off_b_o
);
    p_arm_a_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_a_i && !busy_a_o && !dmarst_a_i) |=> (busy_a_o && !err_vld_a_o));

    p_capture_a_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_b_o && busy_a_o && xfer_i && (par_err_i || frm_err_i)
         && !err_vld_a_o && !dmarst_a_i) |=> err_vld_a_o);

    p_hold_a_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld_a_o && !dmarst_a_i && !(load_a_i && !busy_a_o))
        |=> (err_vld_a_o && $stable(err_off_a_o)));

    p_hold_b_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (err_vld_b_o && !dmarst_b_i && !(load_b_i && !busy_b_o))
        |=> (err_vld_b_o && $stable(err_off_b_o)));

    p_switch_to_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (act_b_o && !busy_b_o && busy_a_o) |=> !act_b_o);

    p_switch_to_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!act_b_o && !busy_a_o && busy_b_o) |=> act_b_o);

    p_clear_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dmarst_a_i |=> (!busy_a_o && !err_vld_a_o && err_off_a_o == '0));

    p_clear_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dmarst_b_i |=> (!busy_b_o && !err_vld_b_o && err_off_b_o == '0));

    p_idle_quiet_a_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_a_o && !err_vld_a_o) |=> !err_vld_a_o);
endmodule

bind rxerr_offset_rec rxerr_offset_rec_chk #(.EOFF_W(EOFF_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_i      (xfer_i),
    .par_err_i   (par_err_i),
    .frm_err_i   (frm_err_i),
    .load_a_i    (load_a_i),
    .load_b_i    (load_b_i),
    .dmarst_a_i  (dmarst_a_i),
    .dmarst_b_i  (dmarst_b_i),
    .act_b_o     (act_b_o),
    .busy_a_o    (busy_a_o),
    .busy_b_o    (busy_b_o),
    .err_vld_a_o (err_vld_a_o),
    .err_off_a_o (err_off_a_o),
    .err_vld_b_o (err_vld_b_o),
    .err_off_b_o (err_off_b_o)
);

// File: tb/test_rxerr_offset_rec.sv
`timescale 1ns/1ps
// Scoreboard bench: step() drives one cycle and queues the expected ports;
// the monitor pops one entry per rising edge and compares 1 ns later.
module test_rxerr_offset_rec;
    localparam int unsigned EW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xfer = 0, par = 0, frm = 0, ovf = 0;
    logic lda = 0, ldb = 0, rsa = 0, rsb = 0;
    logic act_b, busy_a, busy_b, va, vb;
    logic [EW-1:0] oa, ob;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    typedef struct packed {
        logic xfer, par, frm, ovf, lda, ldb, rsa, rsb;
    } stim_t;

    typedef struct {
        bit            chk;
        string         req;
        logic          act, ba, bb, va, vb;
        logic [EW-1:0] oa, ob;
    } exp_t;

    exp_t q[$];

    always #2 clk = ~clk;

    rxerr_offset_rec i_rxerr_offset_rec (
        .clk(clk), .rst_n(rst_n), .xfer_i(xfer), .par_err_i(par), .frm_err_i(frm),
        .ovf_i(ovf), .load_a_i(lda), .load_b_i(ldb), .dmarst_a_i(rsa), .dmarst_b_i(rsb),
        .act_b_o(act_b), .busy_a_o(busy_a), .busy_b_o(busy_b),
        .err_vld_a_o(va), .err_off_a_o(oa), .err_vld_b_o(vb), .err_off_b_o(ob)
    );

    function automatic stim_t s(input bit x, p, f, o, la, lb, ra, rb);
        s = '{xfer: x, par: p, frm: f, ovf: o, lda: la, ldb: lb, rsa: ra, rsb: rb};
    endfunction

    function automatic exp_t e(input string r, input bit a, bba, bbb,
                               input bit ea, input int unsigned fa,
                               input bit eb, input int unsigned fb);
        e.chk = 1; e.req = r; e.act = a; e.ba = bba; e.bb = bbb;
        e.va = ea; e.oa = EW'(fa); e.vb = eb; e.ob = EW'(fb);
    endfunction

    function automatic exp_t nochk();
        nochk.chk = 0; nochk.req = "";
        nochk.act = 0; nochk.ba = 0; nochk.bb = 0; nochk.va = 0; nochk.vb = 0;
        nochk.oa = '0; nochk.ob = '0;
    endfunction

    // Driver: apply one cycle of stimulus and queue what the ports must show after the edge.
    task automatic step(input stim_t st, input exp_t ex);
        @(negedge clk);
        {xfer, par, frm, ovf, lda, ldb, rsa, rsb} = st;
        q.push_back(ex);
    endtask

    // Monitor: compare the queued expectation against the ports after each edge.
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            if (x.chk) begin
                checks++;
                if ({act_b, busy_a, busy_b, va, oa, vb, ob} !==
                    {x.act, x.ba, x.bb, x.va, x.oa, x.vb, x.ob}) begin
                    fails++;
                    $display("FAIL %s: act=%b busyA=%b busyB=%b vA=%b offA=%0d vB=%b offB=%0d expected act=%b busyA=%b busyB=%b vA=%b offA=%0d vB=%b offB=%0d",
                             x.req, act_b, busy_a, busy_b, va, oa, vb, ob,
                             x.act, x.ba, x.bb, x.va, x.oa, x.vb, x.ob);
                end
            end
        end
    end

    stim_t IDLE;

    initial begin
        IDLE = s(0,0,0,0,0,0,0,0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step(IDLE, e("R1", 0,0,0, 0,0, 0,0));
        // R3: flagged transfer while active buffer idle is ignored
        step(s(1,1,0,0,0,0,0,0), e("R3", 0,0,0, 0,0, 0,0));
        // R10: overrun while idle is ignored
        step(s(0,0,0,1,0,0,0,0), e("R10", 0,0,0, 0,0, 0,0));
        // R2: arm A
        step(s(0,0,0,0,1,0,0,0), e("R2", 0,1,0, 0,0, 0,0));
        step(s(1,0,0,0,0,0,0,0), nochk());
        step(s(1,0,0,0,0,0,0,0), e("R3", 0,1,0, 0,0, 0,0));
        // R4: parity error on third character -> offset 2
        step(s(1,1,0,0,0,0,0,0), e("R4", 0,1,0, 1,2, 0,0));
        // R5: later frame error and overrun leave offset alone
        step(s(1,0,1,0,0,0,0,0), e("R5", 0,1,0, 1,2, 0,0));
        step(s(0,0,0,1,0,0,0,0), e("R5", 0,1,0, 1,2, 0,0));
        for (int i = 0; i < 3; i++) step(s(1,0,0,0,0,0,0,0), nochk());
        // R7/R9: eighth transfer completes A; B idle so A stays active; error retained
        step(s(1,0,0,0,0,0,0,0), e("R9", 0,0,0, 1,2, 0,0));
        // R7: arm B, then pointer moves on the following edge
        step(s(0,0,0,0,0,1,0,0), e("R7", 0,0,1, 1,2, 0,0));
        step(IDLE, e("R7", 1,0,1, 1,2, 0,0));
        for (int i = 0; i < 3; i++) step(s(1,0,0,0,0,0,0,0), nochk());
        // R6: overrun after 3 transfers -> 3 + 4 = 7
        step(s(0,0,0,1,0,0,0,0), e("R6", 1,0,1, 1,2, 1,7));
        step(s(1,1,0,0,0,0,0,0), e("R5", 1,0,1, 1,2, 1,7));
        // R2: load on busy B ignored, its error stays
        step(s(0,0,0,0,0,1,0,0), e("R2", 1,0,1, 1,2, 1,7));
        // R9: reload of finished A clears its indication
        step(s(0,0,0,0,1,0,0,0), e("R9", 1,1,1, 0,0, 1,7));
        for (int i = 0; i < 3; i++) step(s(1,0,0,0,0,0,0,0), nochk());
        // R7: B completes with A busy -> switch at the same edge
        step(s(1,0,0,0,0,0,0,0), e("R7", 0,1,0, 0,0, 1,7));
        // R6: flagged transfer and overrun together -> transfer offset 0 wins
        step(s(1,0,1,1,0,0,0,0), e("R6", 0,1,0, 1,0, 1,7));
        // R8: reset beats load on busy A
        step(s(0,0,0,0,1,0,1,0), e("R8", 0,0,0, 0,0, 1,7));
        step(s(0,0,0,0,0,0,0,1), e("R8", 0,0,0, 0,0, 0,0));
        // R6: overrun after 5 clean transfers -> 9
        step(s(0,0,0,0,1,0,0,0), e("R2", 0,1,0, 0,0, 0,0));
        for (int i = 0; i < 5; i++) step(s(1,0,0,0,0,0,0,0), nochk());
        step(s(0,0,0,1,0,0,0,0), e("R6", 0,1,0, 1,9, 0,0));
        step(IDLE, nochk());
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule